// File: doc/BRIEF.md
# I2C Variable-Length Register Reader

This block is the read side of an I2C target. A controller selects an 8-bit subaddress in a short write phase. It then issues a repeated START and reads. Each subaddress has its own byte count. The block tracks two things: which subaddress it is serving and how far into it the transfer has got. Each data byte comes from an internal fetch port that has a ready handshake. While a byte is being fetched, the block holds SCL low, which makes the controller wait.

A sequential read does not stop at the end of a subaddress. After the last byte of one subaddress, the next acknowledged byte is byte 0 of the following subaddress, and the pointer wraps from 0xFF to 0x00. A band of reserved subaddresses never reaches the fetch port. Each of them returns zero bytes with no wait state. A controller NACK or a STOP ends the transfer. The position reached is kept, so a read that starts without a write phase picks up from that position.

Top module: `i2c_varlen_reader`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR is acknowledged (SDA low in the ninth clock). Any other address gets no acknowledge and is ignored until the next START. A write phase (bit 0 = 0) followed by a subaddress byte sets the pointer to that subaddress and the byte index to 0. The first byte of the following read (bit 0 = 1) is byte 0 of that subaddress.
- R2: Byte counts per subaddress are: 0xC9 and 0xED give 8, 0xFD gives 10, 0xFE gives 2, 0xFF gives 1, and every other subaddress gives 4.
- R3: When the controller acknowledges the last byte of a subaddress, the next byte sent is byte 0 of the following subaddress. A read may stop partway through any subaddress.
- R4: Subaddresses from RSV_LO (default 0xC0) up to 0xFC are reserved. They return 0x00 for every byte, never raise fetch_req and never stretch SCL.
- R5: A sequential read past the last byte of 0xFF continues with byte 0 of 0x00.
- R6: A controller NACK ends the transfer. A later read with no write phase continues with the byte after the last one sent.
- R7: After a STOP, both scl_oe and sda_oe are low.
- R8: From the end of the acknowledge clock until fetch_ready, fetch_req stays high with stable fetch_addr and fetch_idx, and SCL is held low (scl_oe high).
- R9: If fetch_ready does not arrive within WAIT_MAX cycles of fetch_req rising, SCL is released and the byte sent is 0x00. The position still advances.
- R10: Bytes are sent MSB first. sda_oe changes only while SCL is low.
- R11: After reset, scl_oe, sda_oe and fetch_req are low, and the pointer and index are 0.
- R12: fetch_addr and fetch_idx give the subaddress and byte index being fetched. fetch_data is captured in the cycle fetch_ready is high, and fetch_req falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sensed SCL bus level |
| sda_i | input | 1 | Sensed SDA bus level |
| scl_oe | output | 1 | Pull SCL low (wait state) |
| sda_oe | output | 1 | Pull SDA low |
| fetch_req | output | 1 | Byte fetch request |
| fetch_addr | output | 8 | Subaddress being fetched |
| fetch_idx | output | 4 | Byte index within the subaddress |
| fetch_ready | input | 1 | Fetch data valid |
| fetch_data | input | 8 | Fetched byte |

## Verification
The bench aims at the points where a subaddress boundary is crossed. These are 0x10 into 0x11, the eight-byte reserved 0xC9, the ten-, two- and one-byte 0xFD to 0xFF run that wraps to 0x00, and the step from 0xBF into the reserved band. A wrong length lookup or a missing wrap shows up there as a byte with the wrong index pattern. It also reads after an early NACK without a write phase, where a design that reset its index would repeat bytes. A fetch that never answers must end in a 0x00 byte, not a bus held low forever. The reserved reads must show no fetch request and no stretching.

// File: rtl/i2c_varlen_reader.sv
module i2c_varlen_reader #(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         WAIT_MAX = 1024,
  parameter logic [7:0] RSV_LO   = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       fetch_req,
  output logic [7:0] fetch_addr,
  output logic [3:0] fetch_idx,
  input  logic       fetch_ready,
  input  logic [7:0] fetch_data
);
  localparam int WW = $clog2(WAIT_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_SUB, S_SACK, S_SKIP, S_FETCH, S_TX, S_TACK
  } st_t;

  function automatic logic [3:0] sub_len(input logic [7:0] a);
    case (a)
      8'hC9, 8'hED: sub_len = 4'd8;
      8'hFD:        sub_len = 4'd10;
      8'hFE:        sub_len = 4'd2;
      8'hFF:        sub_len = 4'd1;
      default:      sub_len = 4'd4;
    endcase
  endfunction

  st_t           st;
  logic [2:0]    scl_q, sda_q;
  logic [7:0]    sh, ptr;
  logic [3:0]    bcnt, idx;
  logic [WW-1:0] wcnt;
  logic          rd, mack;

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire rise  = scl_s & ~scl_q[2];
  wire fall  = ~scl_s & scl_q[2];
  wire start = scl_s & scl_q[2] & sda_q[2] & ~sda_s;
  wire stop  = scl_s & scl_q[2] & ~sda_q[2] & sda_s;
  wire rsv   = (ptr >= RSV_LO) && (ptr <= 8'hFC);
  wire last  = (idx == sub_len(ptr) - 4'd1);

  assign fetch_addr = ptr;
  assign fetch_idx  = idx;
  assign fetch_req  = (st == S_FETCH) && !rsv;
  assign scl_oe     = (st == S_FETCH);
  assign sda_oe     = (st == S_AACK) || (st == S_SACK) || ((st == S_TX) && !sh[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      scl_q <= 3'b111;
      sda_q <= 3'b111;
      sh    <= '0;
      ptr   <= '0;
      idx   <= '0;
      bcnt  <= '0;
      wcnt  <= '0;
      rd    <= 1'b0;
      mack  <= 1'b0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (stop) begin
        st <= S_IDLE;
      end else if (start) begin
        st   <= S_ADDR;
        bcnt <= '0;
      end else begin
        case (st)
          S_ADDR, S_SUB: begin
            if (rise) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (fall && bcnt == 4'd8) begin
              bcnt <= '0;
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rd <= sh[0];
                  st <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                ptr <= sh;
                idx <= '0;
                st  <= S_SACK;
              end
            end
          end
          S_AACK: if (fall) begin
            wcnt <= '0;
            st   <= rd ? S_FETCH : S_SUB;
          end
          S_SACK: if (fall) st <= S_SKIP;
          S_FETCH: begin
            if (rsv) begin
              sh <= 8'h00;
              st <= S_TX;
            end else if (fetch_ready) begin
              sh <= fetch_data;
              st <= S_TX;
            end else if (wcnt == WW'(WAIT_MAX - 1)) begin
              sh <= 8'h00;
              st <= S_TX;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
          S_TX: if (fall) begin
            sh <= {sh[6:0], 1'b0};
            if (bcnt == 4'd7) begin
              bcnt <= '0;
              mack <= 1'b0;
              st   <= S_TACK;
              if (last) begin
                ptr <= ptr + 8'd1;
                idx <= '0;
              end else begin
                idx <= idx + 4'd1;
              end
            end else begin
              bcnt <= bcnt + 4'd1;
            end
          end
          S_TACK: begin
            if (rise) mack <= ~sda_s;
            else if (fall) begin
              wcnt <= '0;
              st   <= mack ? S_FETCH : S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_varlen_reader_chk.sv
module i2c_varlen_reader_chk #(
  parameter int         WAIT_MAX = 1024,
  parameter logic [7:0] RSV_LO   = 8'hC0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       fetch_req,
  input logic [7:0] fetch_addr,
  input logic [3:0] fetch_idx,
  input logic       fetch_ready
);
  function automatic int bytes_of(input logic [7:0] a);
    if (a == 8'hFD) return 10;
    if (a == 8'hFE) return 2;
    if (a == 8'hFF) return 1;
    if (a == 8'hC9 || a == 8'hED) return 8;
    return 4;
  endfunction

  logic [2:0] hi_cnt;
  int         wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      wait_cnt <= 0;
    end else begin
      hi_cnt   <= !scl_i ? 3'd0 : (hi_cnt == 3'd7 ? hi_cnt : hi_cnt + 3'd1);
      wait_cnt <= fetch_req ? wait_cnt + 1 : 0;
    end
  end

  p_sda_quiet_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt >= 3'd4) |-> $stable(sda_oe));
  p_hold_while_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ready && wait_cnt < WAIT_MAX - 1)
      |=> (fetch_req && scl_oe && $stable(fetch_addr) && $stable(fetch_idx)));
  p_wait_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (wait_cnt < WAIT_MAX));
  p_drop_after_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ready) |=> !fetch_req);
  p_idx_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (int'(fetch_idx) < bytes_of(fetch_addr)));
  p_no_reserved_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !(fetch_addr >= RSV_LO && fetch_addr <= 8'hFC));
endmodule

bind i2c_varlen_reader i2c_varlen_reader_chk #(.WAIT_MAX(WAIT_MAX), .RSV_LO(RSV_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_idx(fetch_idx),
  .fetch_ready(fetch_ready)
);

// File: tb/i2c_varlen_reader_tb.sv
module i2c_varlen_reader_tb;
  localparam int         H    = 25;
  localparam int         WMAX = 200;
  localparam logic [6:0] DEV  = 7'h34;
  localparam int         NV   = 8;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {8'h10, 8'd6,  8'd0},
    {8'h12, 8'd4,  8'd60},
    {8'hC9, 8'd9,  8'd0},
    {8'hEB, 8'd6,  8'd5},
    {8'hFD, 8'd14, 8'd3},
    {8'hBE, 8'd10, 8'd2},
    {8'hFC, 8'd3,  8'd0},
    {8'h00, 8'd1,  8'd0}
  };

  logic clk = 0, rst_n = 0;
  logic m_scl = 0, m_sda = 0;
  logic scl_oe, sda_oe, fetch_req, fetch_ready;
  logic [7:0] fetch_addr, fetch_data;
  logic [3:0] fetch_idx;
  wire scl_b = ~(m_scl | scl_oe);
  wire sda_b = ~(m_sda | sda_oe);

  int checks = 0, errors = 0, lat = 0, rcnt = 0, req_rises = 0, stretch = 0;
  logic req_d = 0, done = 0;
  logic [7:0] mp = 0;
  int mi = 0;

  always #2.5 clk = ~clk;

  i2c_varlen_reader #(.DEV_ADDR(DEV), .WAIT_MAX(WMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_b), .sda_i(sda_b), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_idx(fetch_idx), .fetch_ready(fetch_ready), .fetch_data(fetch_data));

  function automatic logic [7:0] pat(input logic [7:0] a, input logic [3:0] i);
    return a ^ {i, 4'h0} ^ 8'h5A;
  endfunction
  function automatic int nbytes(input logic [7:0] a);
    if (a == 8'hC9 || a == 8'hED) return 8;
    if (a == 8'hFD) return 10;
    if (a == 8'hFE) return 2;
    if (a == 8'hFF) return 1;
    return 4;
  endfunction
  function automatic bit is_rsv(input logic [7:0] a);
    return a >= 8'hC0 && a <= 8'hFC;
  endfunction

  always_ff @(posedge clk) begin
    req_d <= fetch_req;
    if (fetch_req && !req_d) req_rises <= req_rises + 1;
    if (!fetch_req || fetch_ready) begin
      rcnt <= 0;
      fetch_ready <= 1'b0;
    end else if (rcnt >= lat) begin
      fetch_ready <= 1'b1;
      fetch_data  <= pat(fetch_addr, fetch_idx);
    end else begin
      rcnt <= rcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic rel_scl();
    m_scl = 0;
    @(negedge clk);
    while (!scl_b) begin
      @(negedge clk);
      stretch++;
    end
  endtask
  task automatic i2c_start();
    m_sda = 1; w(H); m_scl = 1; w(H);
  endtask
  task automatic i2c_rstart();
    m_sda = 0; w(H); rel_scl(); w(H); m_sda = 1; w(H); m_scl = 1; w(H);
  endtask
  task automatic i2c_stop();
    m_sda = 1; w(H); rel_scl(); w(H); m_sda = 0; w(H);
  endtask
  task automatic wbit(input bit b);
    m_sda = !b; w(H); rel_scl(); w(H); m_scl = 1; w(6);
  endtask
  task automatic rbit(output bit b);
    m_sda = 0; w(H); rel_scl(); w(H/2); b = sda_b; w(H/2); m_scl = 1; w(6);
  endtask
  task automatic wbyte(input logic [7:0] d, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(x);
    ack = !x;
  endtask
  task automatic rbyte(output logic [7:0] d, input bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      rbit(x);
      d[i] = x;
    end
    wbit(!ack);
  endtask

  task automatic read_n(input int n, input bit tmo);
    logic [7:0] d, e;
    for (int j = 0; j < n; j++) begin
      stretch = 0;
      rbyte(d, j < n - 1);
      e = (is_rsv(mp) || tmo) ? 8'h00 : pat(mp, mi[3:0]);
      chk(d == e, $sformatf("R1/R2/R3/R5/R10/R12 sub %0h idx %0d", mp, mi), d, e);
      if (lat >= 40 && j == 0) chk(stretch > 0, "R8 wait state", stretch, 1);
      if (is_rsv(mp)) chk(stretch == 0, "R4 no stretch", stretch, 0);
      mi++;
      if (mi == nbytes(mp)) begin
        mi = 0;
        mp = mp + 8'd1;
      end
    end
  endtask

  task automatic post_stop();
    w(4);
    chk(!scl_oe && !sda_oe, "R7 released after stop", {scl_oe, sda_oe}, 0);
  endtask

  task automatic rand_read(input logic [7:0] sub, input int n, input bit tmo);
    bit ack;
    i2c_start();
    wbyte({DEV, 1'b0}, ack); chk(ack, "R1 write address ack", ack, 1);
    wbyte(sub, ack);         chk(ack, "R1 subaddress ack", ack, 1);
    i2c_rstart();
    wbyte({DEV, 1'b1}, ack); chk(ack, "R1 read address ack", ack, 1);
    mp = sub; mi = 0;
    read_n(n, tmo);
    i2c_stop();
    post_stop();
  endtask

  task automatic cur_read(input int n, input bit tmo);
    bit ack;
    i2c_start();
    wbyte({DEV, 1'b1}, ack); chk(ack, "R6 current read ack", ack, 1);
    read_n(n, tmo);
    i2c_stop();
    post_stop();
  endtask

  initial begin
    int r0;
    bit ack;
    w(5);
    rst_n = 1;
    w(3);
    chk(!scl_oe && !sda_oe && !fetch_req, "R11 reset outputs", {scl_oe, sda_oe, fetch_req}, 0);
    mp = 0; mi = 0;
    cur_read(1, 0);

    for (int v = 0; v < NV; v++) begin
      lat = int'(VEC[v][7:0]);
      r0 = req_rises;
      rand_read(VEC[v][23:16], int'(VEC[v][15:8]), 0);
      if (v == 2) chk(req_rises == r0, "R4 no fetch in reserved", req_rises - r0, 0);
    end

    lat = 0;
    r0 = req_rises;
    i2c_start();
    wbyte({7'h35, 1'b1}, ack);
    chk(!ack, "R1 foreign address ignored", ack, 0);
    i2c_stop();
    chk(req_rises == r0, "R1 no fetch for foreign address", req_rises - r0, 0);

    rand_read(8'h20, 2, 0);
    cur_read(3, 0);

    lat = 250;
    rand_read(8'h30, 2, 1);
    lat = 0;
    cur_read(1, 0);
    chk(mp == 8'h30 && mi == 3, "R9 position advanced after timeout", mi, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule